// File: doc/BRIEF.md
# Software-Managed Address Translation Buffer

This block translates 32-bit virtual addresses into physical addresses through a small, fully associative set of page mappings. Pages are 4 KB, so the low 12 address bits pass through unchanged and the upper 20 bits form the virtual page number. Every entry carries a process identifier, so mappings that belong to different tasks can sit side by side without a flush. Each request returns its answer one cycle later: either a hit with the physical address, or one encoded fault cause.

There is no hardware walk of page tables. A lookup that finds no mapping, or that breaks an entry's read or write permission, faults to software. The miss handler then installs the mapping through a maintenance port. That port accepts commands only in privileged mode. Each entry keeps a touched bit and a dirty bit. Software samples these to make epoch-based replacement and writeback decisions. A single command clears all touched bits in one cycle, and a status command reads back one entry's bits by index.

Top module: `xlate_buf`

## Requirements
- R1: On a hit, `rsp_paddr_o` equals the entry's physical page number concatenated with `lk_vaddr_i[11:0]`. The virtual page number is `lk_vaddr_i[31:12]`.
- R2: `rsp_valid_o` follows `lk_valid_i` one cycle later. When it is set, exactly one of `rsp_hit_o` or a nonzero `rsp_fault_o` is asserted. The fault codes are 0 none, 1 miss, 2 read violation, 3 write violation. When it is clear, hit, fault and address are all 0.
- R3: A lookup faults with code 1 when no valid entry matches both the page number and `lk_pid_i`. A matching tag under a different process identifier, or an invalidated entry, also gives code 1.
- R4: A matched read (`lk_write_i`=0) to an entry without read permission faults with code 2. A matched write to an entry without write permission faults with code 3. On any fault, `rsp_paddr_o` is 0.
- R5: If several valid entries match, the lowest-indexed one supplies the result.
- R6: A lookup that hits sets the touched bit of the matched entry. A lookup that faults changes no touched or dirty bit.
- R7: A write lookup that hits sets the matched entry's dirty bit. A read hit leaves the dirty bit unchanged.
- R8: Command 2 (clear touched) zeroes every touched bit in one cycle. A hit in the same cycle leaves its own entry touched.
- R9: Commands 1, 2 and 3 on `mt_op_i` take effect only with `mt_priv_i`=1. With `mt_priv_i`=0, a nonzero command pulses `mt_fault_o` one cycle later and changes no state.
- R10: Command 1 writes the valid bit, page tag, process identifier, physical page number and permissions of the entry at `mt_idx_i`, and clears that entry's touched and dirty bits. This write takes priority over a hit to the same entry in the same cycle. A lookup in the same cycle as the write sees the old contents.
- R11: Command 3 makes `st_valid_o` high one cycle later, with `st_touched_o` and `st_dirty_o` showing the bits of entry `mt_idx_i` as they stood before that cycle's updates.
- R12: After reset, all entries are invalid, all touched and dirty bits are 0, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_vaddr_i | input | 32 | Virtual address |
| lk_write_i | input | 1 | 1 = write access, 0 = read access |
| lk_pid_i | input | 8 | Requesting process identifier |
| rsp_valid_o | output | 1 | Lookup result valid |
| rsp_hit_o | output | 1 | Translation succeeded |
| rsp_fault_o | output | 2 | Fault cause (0 none, 1 miss, 2 read, 3 write) |
| rsp_paddr_o | output | 32 | Physical address |
| mt_op_i | input | 2 | Command: 0 none, 1 write entry, 2 clear touched, 3 read status |
| mt_priv_i | input | 1 | Command issued in privileged mode |
| mt_idx_i | input | 4 | Entry index for commands 1 and 3 |
| mt_valid_i | input | 1 | Valid bit to write |
| mt_vpn_i | input | 20 | Virtual page tag to write |
| mt_pid_i | input | 8 | Process identifier to write |
| mt_ppn_i | input | 20 | Physical page number to write |
| mt_rd_i | input | 1 | Read permission to write |
| mt_wr_i | input | 1 | Write permission to write |
| mt_fault_o | output | 1 | Privilege fault on a user-mode command |
| st_valid_o | output | 1 | Status readback valid |
| st_touched_o | output | 1 | Touched bit of the selected entry |
| st_dirty_o | output | 1 | Dirty bit of the selected entry |

## Verification
The hardest situations to reach are the ones where a lookup and a maintenance command land in the same cycle on the same entry. One case is a clear-touched command alongside a hit. The other is a rewrite of the very entry being looked up. In each case, the result depends on which update wins and on the lookup seeing pre-write contents. The stimulus drives these pairs deliberately on one edge and then reads the touched and dirty bits back through the status command. Duplicate mappings never arise in normal use, so software must install the same tag and process identifier at two indices on purpose to exercise the priority rule. A long mixed sequence over a handful of pages and two processes then drives all these cases against the reference model.

// File: rtl/xlate_pkg.sv
`timescale 1ns/1ps
package xlate_pkg;
  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_MISS  = 2'd1,
    FLT_RPROT = 2'd2,
    FLT_WPROT = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_WRITE = 2'd1,
    OP_CLR   = 2'd2,
    OP_STAT  = 2'd3
  } mt_op_e;
endpackage

// File: rtl/xlate_store.sv
`timescale 1ns/1ps
module xlate_store #(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PID_W = 8,
  parameter int PPN_W = 20,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic                      clr_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic                      w_valid_i,
  input  logic [VPN_W-1:0]          w_vpn_i,
  input  logic [PID_W-1:0]          w_pid_i,
  input  logic [PPN_W-1:0]          w_ppn_i,
  input  logic                      w_rd_i,
  input  logic                      w_wr_i,
  input  logic [N-1:0]              set_t_i,
  input  logic [N-1:0]              set_d_i,
  output logic [N-1:0]              valid_o,
  output logic [N-1:0][VPN_W-1:0]   vpn_o,
  output logic [N-1:0][PID_W-1:0]   pid_o,
  output logic [N-1:0][PPN_W-1:0]   ppn_o,
  output logic [N-1:0]              rd_o,
  output logic [N-1:0]              wr_o,
  output logic [N-1:0]              touched_o,
  output logic [N-1:0]              dirty_o
);
  logic [N-1:0]            valid_q, rd_q, wr_q, touched_q, dirty_q;
  logic [N-1:0]            touched_d, dirty_d;
  logic [N-1:0][VPN_W-1:0] vpn_q;
  logic [N-1:0][PID_W-1:0] pid_q;
  logic [N-1:0][PPN_W-1:0] ppn_q;

  // install wins over a same-cycle hit; a hit wins over clear
  always_comb begin
    for (int i = 0; i < N; i++) begin
      touched_d[i] = (clr_i ? 1'b0 : touched_q[i]) | set_t_i[i];
      dirty_d[i]   = dirty_q[i] | set_d_i[i];
      if (we_i && idx_i == IDX_W'(i)) begin
        touched_d[i] = 1'b0;
        dirty_d[i]   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= '0;
      rd_q      <= '0;
      wr_q      <= '0;
      vpn_q     <= '0;
      pid_q     <= '0;
      ppn_q     <= '0;
      touched_q <= '0;
      dirty_q   <= '0;
    end else begin
      if (we_i) begin
        valid_q[idx_i] <= w_valid_i;
        vpn_q[idx_i]   <= w_vpn_i;
        pid_q[idx_i]   <= w_pid_i;
        ppn_q[idx_i]   <= w_ppn_i;
        rd_q[idx_i]    <= w_rd_i;
        wr_q[idx_i]    <= w_wr_i;
      end
      touched_q <= touched_d;
      dirty_q   <= dirty_d;
    end
  end

  assign valid_o   = valid_q;
  assign vpn_o     = vpn_q;
  assign pid_o     = pid_q;
  assign ppn_o     = ppn_q;
  assign rd_o      = rd_q;
  assign wr_o      = wr_q;
  assign touched_o = touched_q;
  assign dirty_o   = dirty_q;

  // R10
  entry_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(valid_q));
  // R8
  clear_touched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((touched_q & ~$past(set_t_i)) == '0));
  // R7
  dirty_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_d_i != '0 && !we_i) |=> ((dirty_q & $past(set_d_i)) == $past(set_d_i)));
endmodule

// File: rtl/xlate_cam.sv
`timescale 1ns/1ps
module xlate_cam #(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PID_W = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0][VPN_W-1:0] vpn_i,
  input  logic [N-1:0][PID_W-1:0] pid_i,
  input  logic [VPN_W-1:0]        lk_vpn_i,
  input  logic [PID_W-1:0]        lk_pid_i,
  output logic                    hit_o,
  output logic [IDX_W-1:0]        idx_o
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (vpn_i[g] == lk_vpn_i) && (pid_i[g] == lk_pid_i);
  end

  // lowest index wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  // R5
  cam_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (match[idx_o] && $countones(match & ((N'(1) << idx_o) - N'(1))) == 0));
endmodule

// File: rtl/xlate_buf.sv
`timescale 1ns/1ps
module xlate_buf
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PID_W   = 8,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PPN_W  = PA_W - OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_valid_i,
  input  logic [VA_W-1:0]  lk_vaddr_i,
  input  logic             lk_write_i,
  input  logic [PID_W-1:0] lk_pid_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic [1:0]       rsp_fault_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  input  logic [1:0]       mt_op_i,
  input  logic             mt_priv_i,
  input  logic [IDX_W-1:0] mt_idx_i,
  input  logic             mt_valid_i,
  input  logic [VPN_W-1:0] mt_vpn_i,
  input  logic [PID_W-1:0] mt_pid_i,
  input  logic [PPN_W-1:0] mt_ppn_i,
  input  logic             mt_rd_i,
  input  logic             mt_wr_i,
  output logic             mt_fault_o,
  output logic             st_valid_o,
  output logic             st_touched_o,
  output logic             st_dirty_o
);
  logic [ENTRIES-1:0]            e_valid, e_rd, e_wr, e_touched, e_dirty;
  logic [ENTRIES-1:0][VPN_W-1:0] e_vpn;
  logic [ENTRIES-1:0][PID_W-1:0] e_pid;
  logic [ENTRIES-1:0][PPN_W-1:0] e_ppn;
  logic [ENTRIES-1:0]            set_t, set_d;
  logic                          cam_hit, access_ok;
  logic [IDX_W-1:0]              cam_idx;
  fault_e                        fault_d;
  mt_op_e                        op;
  logic                          do_write, do_clr, do_stat, priv_fault;

  assign op         = mt_op_e'(mt_op_i);
  assign do_write   = mt_priv_i && (op == OP_WRITE);
  assign do_clr     = mt_priv_i && (op == OP_CLR);
  assign do_stat    = mt_priv_i && (op == OP_STAT);
  assign priv_fault = !mt_priv_i && (op != OP_NOP);

  xlate_cam #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_cam (
    .clk_i, .rst_ni,
    .valid_i (e_valid),
    .vpn_i   (e_vpn),
    .pid_i   (e_pid),
    .lk_vpn_i(lk_vaddr_i[VA_W-1:OFF_W]),
    .lk_pid_i,
    .hit_o   (cam_hit),
    .idx_o   (cam_idx)
  );

  always_comb begin
    if (!cam_hit)                          fault_d = FLT_MISS;
    else if (lk_write_i && !e_wr[cam_idx]) fault_d = FLT_WPROT;
    else if (!lk_write_i && !e_rd[cam_idx]) fault_d = FLT_RPROT;
    else                                   fault_d = FLT_NONE;
    access_ok = lk_valid_i && (fault_d == FLT_NONE);
    set_t = '0;
    set_d = '0;
    if (access_ok) begin
      set_t[cam_idx] = 1'b1;
      set_d[cam_idx] = lk_write_i;
    end
  end

  xlate_store #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W), .PPN_W(PPN_W)) u_store (
    .clk_i, .rst_ni,
    .we_i     (do_write),
    .clr_i    (do_clr),
    .idx_i    (mt_idx_i),
    .w_valid_i(mt_valid_i),
    .w_vpn_i  (mt_vpn_i),
    .w_pid_i  (mt_pid_i),
    .w_ppn_i  (mt_ppn_i),
    .w_rd_i   (mt_rd_i),
    .w_wr_i   (mt_wr_i),
    .set_t_i  (set_t),
    .set_d_i  (set_d),
    .valid_o  (e_valid),
    .vpn_o    (e_vpn),
    .pid_o    (e_pid),
    .ppn_o    (e_ppn),
    .rd_o     (e_rd),
    .wr_o     (e_wr),
    .touched_o(e_touched),
    .dirty_o  (e_dirty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_hit_o    <= 1'b0;
      rsp_fault_o  <= FLT_NONE;
      rsp_paddr_o  <= '0;
      mt_fault_o   <= 1'b0;
      st_valid_o   <= 1'b0;
      st_touched_o <= 1'b0;
      st_dirty_o   <= 1'b0;
    end else begin
      rsp_valid_o  <= lk_valid_i;
      rsp_hit_o    <= access_ok;
      rsp_fault_o  <= lk_valid_i ? fault_d : FLT_NONE;
      rsp_paddr_o  <= access_ok ? {e_ppn[cam_idx], lk_vaddr_i[OFF_W-1:0]} : '0;
      mt_fault_o   <= priv_fault;
      st_valid_o   <= do_stat;
      st_touched_o <= do_stat && e_touched[mt_idx_i];
      st_dirty_o   <= do_stat && e_dirty[mt_idx_i];
    end
  end

  // R2
  rsp_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_hit_o != (rsp_fault_o != 2'd0)));
  // R2
  rsp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!rsp_hit_o && rsp_fault_o == 2'd0 && rsp_paddr_o == '0));
  // R4
  fault_paddr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_paddr_o == '0));
  // R9
  user_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mt_op_i != 2'd0 && !mt_priv_i) |=> (mt_fault_o && !st_valid_o));
endmodule

// File: tb/tb_xlate_buf.sv
`timescale 1ns/1ps
module tb_xlate_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_v = 0, lk_w = 0;
  logic [31:0] lk_a = 0;
  logic [7:0]  lk_p = 0;
  logic [1:0]  op = 0;
  logic        priv = 0, w_v = 0, w_rd = 0, w_wr = 0;
  logic [3:0]  idx = 0;
  logic [19:0] w_vpn = 0, w_ppn = 0;
  logic [7:0]  w_pid = 0;

  logic        rsp_valid, rsp_hit, mt_fault, st_valid, st_t, st_d;
  logic [1:0]  rsp_fault;
  logic [31:0] rsp_paddr;

  always #2.5 clk = ~clk;

  xlate_buf dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_v), .lk_vaddr_i(lk_a), .lk_write_i(lk_w), .lk_pid_i(lk_p),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_fault_o(rsp_fault),
    .rsp_paddr_o(rsp_paddr),
    .mt_op_i(op), .mt_priv_i(priv), .mt_idx_i(idx), .mt_valid_i(w_v),
    .mt_vpn_i(w_vpn), .mt_pid_i(w_pid), .mt_ppn_i(w_ppn), .mt_rd_i(w_rd),
    .mt_wr_i(w_wr), .mt_fault_o(mt_fault),
    .st_valid_o(st_valid), .st_touched_o(st_t), .st_dirty_o(st_d)
  );

  // reference state
  bit        m_v [16], m_r [16], m_w [16], m_t [16], m_d [16];
  bit [19:0] m_vpn [16], m_ppn [16];
  bit [7:0]  m_pid [16];
  logic        e_rv, e_hit, e_mf, e_sv, e_st, e_sd;
  logic [1:0]  e_f;
  logic [31:0] e_pa;
  int checks = 0, fails = 0;
  string cur_req = "R12";

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_step();
    int hi = -1;
    e_rv = lk_v; e_hit = 0; e_f = 0; e_pa = 0;
    if (lk_v) begin
      for (int i = 0; i < 16; i++)
        if (hi < 0 && m_v[i] && m_vpn[i] == lk_a[31:12] && m_pid[i] == lk_p) hi = i;
      if (hi < 0) e_f = 1;
      else if (lk_w && !m_w[hi]) e_f = 3;
      else if (!lk_w && !m_r[hi]) e_f = 2;
      else begin e_hit = 1; e_pa = {m_ppn[hi], lk_a[11:0]}; end
    end
    e_mf = (op != 0) && !priv;
    e_sv = priv && op == 3;
    e_st = e_sv ? m_t[idx] : 1'b0;
    e_sd = e_sv ? m_d[idx] : 1'b0;
    if (priv && op == 2) for (int i = 0; i < 16; i++) m_t[i] = 0;
    if (e_hit) begin m_t[hi] = 1; if (lk_w) m_d[hi] = 1; end
    if (priv && op == 1) begin
      m_v[idx] = w_v; m_vpn[idx] = w_vpn; m_pid[idx] = w_pid; m_ppn[idx] = w_ppn;
      m_r[idx] = w_rd; m_w[idx] = w_wr; m_t[idx] = 0; m_d[idx] = 0;
    end
  endtask

  task automatic compare();
    chk("rsp_valid", 32'(rsp_valid), 32'(e_rv));
    chk("rsp_hit",   32'(rsp_hit),   32'(e_hit));
    chk("rsp_fault", 32'(rsp_fault), 32'(e_f));
    chk("rsp_paddr", rsp_paddr,      e_pa);
    chk("mt_fault",  32'(mt_fault),  32'(e_mf));
    chk("st_valid",  32'(st_valid),  32'(e_sv));
    chk("st_touched", 32'(st_t),     32'(e_st));
    chk("st_dirty",  32'(st_d),      32'(e_sd));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    lk_v = 0; lk_w = 0; op = 0; priv = 0;
  endtask

  task automatic look(logic [31:0] a, logic w, logic [7:0] p);
    lk_v = 1; lk_a = a; lk_w = w; lk_p = p;
  endtask

  task automatic inst(logic pv, logic [3:0] i, logic v, logic [19:0] vpn,
                      logic [7:0] pid, logic [19:0] ppn, logic r, logic w);
    op = 1; priv = pv; idx = i; w_v = v; w_vpn = vpn; w_pid = pid;
    w_ppn = ppn; w_rd = r; w_wr = w;
  endtask

  task automatic stat(logic [3:0] i);
    op = 3; priv = 1; idx = i;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R12: reset state
    repeat (2) @(negedge clk);
    e_rv = 0; e_hit = 0; e_f = 0; e_pa = 0; e_mf = 0; e_sv = 0; e_st = 0; e_sd = 0;
    compare();
    rst_n = 1;
    @(negedge clk);
    stat(0); tick(); tick();
    cur_req = "R3"; look(32'h1234_5678, 0, 3); tick();

    // R9: user install ignored
    cur_req = "R9";
    inst(0, 0, 1, 20'h12345, 3, 20'hABCDE, 1, 1); tick();
    look(32'h1234_5678, 0, 3); tick();
    op = 2; priv = 0; tick();
    stat(0); priv = 0; tick();

    // R1/R2 install and hit
    cur_req = "R1";
    inst(1, 0, 1, 20'h12345, 3, 20'hABCDE, 1, 1); tick();
    look(32'h1234_5678, 0, 3); tick();
    cur_req = "R2"; tick();
    // R3: pid mismatch
    cur_req = "R3"; look(32'h1234_5678, 0, 4); tick();
    // R4: permissions
    cur_req = "R4";
    inst(1, 1, 1, 20'h00010, 3, 20'h00777, 1, 0); tick();
    inst(1, 2, 1, 20'h00020, 3, 20'h00888, 0, 1); tick();
    look(32'h0001_0ABC, 1, 3); tick();
    look(32'h0002_0123, 0, 3); tick();
    look(32'h0002_0FFF, 1, 3); tick();
    // R6: faulted access not touched
    cur_req = "R6"; stat(1); tick(); stat(2); tick(); stat(0); tick();
    // R7: dirty on write hit
    cur_req = "R7"; look(32'h1234_5000, 1, 3); tick(); stat(0); tick();
    look(32'h0001_0000, 0, 3); tick(); stat(1); tick();
    // R5: duplicate mapping
    cur_req = "R5";
    inst(1, 5, 1, 20'h00040, 7, 20'h55555, 1, 1); tick();
    inst(1, 3, 1, 20'h00040, 7, 20'h33333, 1, 1); tick();
    look(32'h0004_0010, 0, 7); tick();
    stat(5); tick(); stat(3); tick();
    // R8: clear with a same-cycle hit
    cur_req = "R8";
    op = 2; priv = 1; look(32'h0001_0004, 0, 3); tick();
    stat(0); tick(); stat(1); tick(); stat(3); tick(); stat(0); tick();
    // R10: rewrite under lookup, then invalidate
    cur_req = "R10";
    look(32'h1234_5000, 1, 3); inst(1, 0, 1, 20'h12345, 3, 20'h0BEEF, 1, 1); tick();
    stat(0); tick();
    look(32'h1234_5000, 0, 3); tick();
    inst(1, 0, 0, 20'h12345, 3, 20'h0BEEF, 1, 1); tick();
    look(32'h1234_5000, 0, 3); tick();
    // R11: status reflects pre-update state
    cur_req = "R11";
    look(32'h0004_0000, 1, 7); stat(3); tick(); stat(3); tick();

    // mixed sequence
    cur_req = "R2";
    for (int n = 0; n < 400; n++) begin
      int k = $urandom_range(0, 9);
      if ($urandom_range(0, 1) == 1)
        look({18'h0, 2'($urandom_range(0, 3)), 12'($urandom)}, 1'($urandom), 8'($urandom_range(0, 1)));
      if (k < 2) inst(1'($urandom_range(0, 3) != 0), 4'($urandom), 1'($urandom_range(0, 3) != 0),
                      20'($urandom_range(0, 3)), 8'($urandom_range(0, 1)), 20'($urandom),
                      1'($urandom), 1'($urandom));
      else if (k == 2) begin op = 2; priv = 1'($urandom); end
      else if (k < 5) begin stat(4'($urandom)); priv = 1'($urandom_range(0, 3) != 0); end
      tick();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule